// File: doc/BRIEF.md
# Cross-Processor Handshake Register

This block connects two processors, called side A and side B, through a pair of 16-bit handshake words. Both sides reach the block through their own simple register bus, and both use the same I/O address. Each side publishes a 4-bit value that the other side reads back as an input nibble. Each side also keeps an interrupt-enable bit. A side can ask for an interrupt on the other side, and that request only takes effect when the other side has its enable bit set.

Each side's view of the word has a fixed layout. Bits [3:0] hold the nibble the peer published. Bits [11:8] hold the side's own published nibble. Bit 14 is the side's interrupt enable. Bit 13 is a write-only request bit. All other bits read as zero. Reads are combinational from the stored state. Writes take effect at the clock edge. Software on either side uses this word to step through a handshake with the other processor, one nibble at a time, and can wake the peer with the request bit.

Top module: `ipcs_link`

## Requirements
- R1: After reset, both views read 0x0000 at the sync address and neither interrupt output is high.
- R2: A read returns the view only when the address equals SYNC_ADDR (default 0x04000180), and returns 0 otherwise. A write to any other address changes no state and raises no interrupt.
- R3: When a side writes, bits [11:8] of its data appear in bits [11:8] of its own view and in bits [3:0] of the peer's view from the next cycle on.
- R4: When a side writes, bit 14 of its data becomes its own interrupt-enable bit (bit 14 of its own view).
- R5: A side's write leaves bits [3:0] of its own view unchanged. Bits 15, 13, 12 and [7:4] of either view always read 0, whatever was written.
- R6: A write with bit 13 set, while the peer's enable bit is 1 before that edge, raises the peer's interrupt output for exactly the one cycle after the write.
- R7: A write with bit 13 set, while the peer's enable bit is 0, raises no interrupt.
- R8: When both sides write in the same cycle, each write's own and peer updates are applied together, and each interrupt request is gated by the peer's enable as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | ADDR_W | Side A address |
| a_wr | input | 1 | Side A write strobe |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A read data (combinational) |
| a_irq | output | 1 | One-cycle interrupt pulse to side A |
| b_addr | input | ADDR_W | Side B address |
| b_wr | input | 1 | Side B write strobe |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B read data (combinational) |
| b_irq | output | 1 | One-cycle interrupt pulse to side B |

## Verification
The assertions assume that the address and write strobes are stable and known at each clock edge. They also assume that a side's enable bit, as read through its own view, is the value that gates the request at that edge. The stimulus changes inputs only at the falling clock edge. It mixes directed writes with pseudo-random traffic in which addresses alternate between the sync address and a neighbouring one. This covers simultaneous writes, requests to a disabled peer, and misaddressed writes. A reference model in the bench tracks both enable bits and both nibbles, so every request's gating is predicted from the enable state before the edge.

// File: rtl/ipcs_pkg.sv
package ipcs_pkg;
    localparam int WORD_W  = 16;
    localparam int NIB_W   = 4;
    localparam int IN_LSB  = 0;
    localparam int OUT_LSB = 8;
    localparam int REQ_BIT = 13;
    localparam int IE_BIT  = 14;

    typedef struct packed {
        logic             ie;
        logic [NIB_W-1:0] nib;
    } side_t;

    typedef struct packed {
        side_t side_a;
        side_t side_b;
        logic  irq_a;
        logic  irq_b;
    } link_st_t;
endpackage

// File: rtl/ipcs_match.sv
module ipcs_match #(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] MATCH  = 32'h0400_0180
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              hit,
    output logic              wr_hit
);
    localparam logic [ADDR_W-1:0] MATCH_W = MATCH[ADDR_W-1:0];

    always_comb begin
        hit    = (addr == MATCH_W);
        wr_hit = hit & wr;
    end
endmodule

// File: rtl/ipcs_view.sv
module ipcs_view
    import ipcs_pkg::*;
(
    input  ipcs_pkg::side_t    own,
    input  logic [NIB_W-1:0]   peer_nib,
    input  logic               hit,
    output logic [WORD_W-1:0]  word,
    output logic [WORD_W-1:0]  rdata
);
    always_comb begin
        word = '0;
        word[IN_LSB  +: NIB_W] = peer_nib;
        word[OUT_LSB +: NIB_W] = own.nib;
        word[IE_BIT]           = own.ie;
        rdata = hit ? word : '0;
    end
endmodule

// File: rtl/ipcs_link.sv
module ipcs_link
    import ipcs_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] SYNC_ADDR = 32'h0400_0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wr,
    input  logic [15:0]       a_wdata,
    output logic [15:0]       a_rdata,
    output logic              a_irq,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wr,
    input  logic [15:0]       b_wdata,
    output logic [15:0]       b_rdata,
    output logic              b_irq
);
    localparam int SIDES = 2;

    logic [ADDR_W-1:0] addr_s  [SIDES];
    logic              wr_s    [SIDES];
    logic              hit_s   [SIDES];
    logic              wrhit_s [SIDES];
    logic [WORD_W-1:0] word_s  [SIDES];
    logic [WORD_W-1:0] rd_s    [SIDES];
    side_t             own_s   [SIDES];
    logic [NIB_W-1:0]  peer_s  [SIDES];

    link_st_t st_q, st_d;

    always_comb begin
        addr_s[0] = a_addr;
        addr_s[1] = b_addr;
        wr_s[0]   = a_wr;
        wr_s[1]   = b_wr;
        own_s[0]  = st_q.side_a;
        own_s[1]  = st_q.side_b;
        peer_s[0] = st_q.side_b.nib;
        peer_s[1] = st_q.side_a.nib;
    end

    for (genvar i = 0; i < SIDES; i++) begin : g_side
        ipcs_match #(.ADDR_W(ADDR_W), .MATCH(SYNC_ADDR)) u_match (
            .addr   (addr_s[i]),
            .wr     (wr_s[i]),
            .hit    (hit_s[i]),
            .wr_hit (wrhit_s[i])
        );
        ipcs_view u_view (
            .own      (own_s[i]),
            .peer_nib (peer_s[i]),
            .hit      (hit_s[i]),
            .word     (word_s[i]),
            .rdata    (rd_s[i])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.irq_a = 1'b0;
        st_d.irq_b = 1'b0;
        if (wrhit_s[0]) begin
            st_d.side_a.ie  = a_wdata[IE_BIT];
            st_d.side_a.nib = a_wdata[OUT_LSB +: NIB_W];
            st_d.irq_b      = a_wdata[REQ_BIT] & st_q.side_b.ie;
        end
        if (wrhit_s[1]) begin
            st_d.side_b.ie  = b_wdata[IE_BIT];
            st_d.side_b.nib = b_wdata[OUT_LSB +: NIB_W];
            st_d.irq_a      = b_wdata[REQ_BIT] & st_q.side_a.ie;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_rdata = rd_s[0];
    assign b_rdata = rd_s[1];
    assign a_irq   = st_q.irq_a;
    assign b_irq   = st_q.irq_b;

    AST_PEER_NIB_A: assert property (@(posedge clk) disable iff (!rst_n)
        wrhit_s[0] |=> word_s[1][IN_LSB +: NIB_W] == $past(a_wdata[OUT_LSB +: NIB_W])); // R3
    AST_PEER_NIB_B: assert property (@(posedge clk) disable iff (!rst_n)
        wrhit_s[1] |=> word_s[0][IN_LSB +: NIB_W] == $past(b_wdata[OUT_LSB +: NIB_W])); // R3
    AST_OWN_IN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrhit_s[0] && !wrhit_s[1]) |=> $stable(word_s[0][IN_LSB +: NIB_W])); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrhit_s[0] && !wrhit_s[1]) |=> ($stable(word_s[0]) && $stable(word_s[1]))); // R2
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wrhit_s[0] && a_wdata[REQ_BIT] && !word_s[1][IE_BIT]) |=> !b_irq); // R7
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wrhit_s[1] && b_wdata[REQ_BIT] && word_s[0][IE_BIT]) |=> a_irq); // R6
endmodule

// File: tb/sim_ipcs_link.sv
module sim_ipcs_link;
    localparam logic [31:0] SYNC  = 32'h0400_0180;
    localparam logic [31:0] OTHER = 32'h0400_0184;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_addr = SYNC, b_addr = SYNC;
    logic        a_wr = 1'b0, b_wr = 1'b0;
    logic [15:0] a_wdata = '0, b_wdata = '0;
    logic [15:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    always #4 clk = ~clk;

    ipcs_link u0 (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wr(a_wr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(b_addr), .b_wr(b_wr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
    );

    typedef struct {
        logic [15:0] ra;
        logic [15:0] rb;
        logic        ia;
        logic        ib;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // reference model
    logic       m_ie_a = 0, m_ie_b = 0;
    logic [3:0] m_nib_a = 0, m_nib_b = 0;
    logic       m_pa = 0, m_pb = 0;

    function automatic logic [15:0] view(logic ie, logic [3:0] own, logic [3:0] peer);
        return {1'b0, ie, 2'b00, own, 4'b0000, peer};
    endfunction

    task automatic step(input logic aw, input logic [31:0] aa, input logic [15:0] ad,
                        input logic bw, input logic [31:0] ba, input logic [15:0] bd,
                        input string tag);
        exp_t e;
        logic ha, hb, ie_a0, ie_b0;
        @(negedge clk);
        a_wr = aw; a_addr = aa; a_wdata = ad;
        b_wr = bw; b_addr = ba; b_wdata = bd;
        ha = aw && (aa == SYNC);
        hb = bw && (ba == SYNC);
        e.ra  = (aa == SYNC) ? view(m_ie_a, m_nib_a, m_nib_b) : 16'h0;
        e.rb  = (ba == SYNC) ? view(m_ie_b, m_nib_b, m_nib_a) : 16'h0;
        e.ia  = m_pa;
        e.ib  = m_pb;
        e.tag = tag;
        q.push_back(e);
        ie_a0 = m_ie_a; ie_b0 = m_ie_b;
        m_pa = hb && bd[13] && ie_a0;
        m_pb = ha && ad[13] && ie_b0;
        if (ha) begin m_ie_a = ad[14]; m_nib_a = ad[11:8]; end
        if (hb) begin m_ie_b = bd[14]; m_nib_b = bd[11:8]; end
    endtask

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "a_rdata", a_rdata, e.ra);
                chk(e.tag, "b_rdata", b_rdata, e.rb);
                chk(e.tag, "a_irq", {15'b0, a_irq}, {15'b0, e.ia});
                chk(e.tag, "b_irq", {15'b0, b_irq}, {15'b0, e.ib});
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, SYNC, 16'h0, 0, SYNC, 16'h0, "R1");         // reset view
        step(1, SYNC, 16'h0500, 0, SYNC, 16'h0, "R3");
        step(0, SYNC, 16'h0, 1, SYNC, 16'h4A00, "R3");      // R3 peer nibble, R4 own enable
        step(0, SYNC, 16'h0, 0, SYNC, 16'h0, "R4");
        step(1, SYNC, 16'h2300, 0, SYNC, 16'h0, "R6");      // b enabled -> b_irq
        step(0, SYNC, 16'h0, 1, SYNC, 16'h2000, "R6");      // a disabled -> none (R7)
        step(0, SYNC, 16'h0, 0, SYNC, 16'h0, "R7");
        step(1, OTHER, 16'h4F00, 1, OTHER, 16'h6F00, "R2"); // ignored writes
        step(0, OTHER, 16'h0, 0, OTHER, 16'h0, "R2");
        step(0, SYNC, 16'h0, 0, SYNC, 16'h0, "R2");
        step(1, SYNC, 16'h4C00, 1, SYNC, 16'h4700, "R8");   // simultaneous
        step(1, SYNC, 16'h6100, 1, SYNC, 16'h6200, "R8");   // both request, both enabled
        step(0, SYNC, 16'h0, 0, SYNC, 16'h0, "R8");
        step(1, SYNC, 16'hFFFF, 0, SYNC, 16'h0, "R5");      // reserved bits stay 0
        step(0, SYNC, 16'h0, 1, SYNC, 16'hBFFF, "R5");
        step(1, SYNC, 16'h0000, 0, SYNC, 16'h0, "R5");
        step(0, SYNC, 16'h0, 0, SYNC, 16'h0, "R5");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rnd;
            rnd = $urandom;
            step(rnd[0], rnd[1] ? OTHER : SYNC, rnd[31:16],
                 rnd[2], rnd[3] ? SYNC : OTHER, {rnd[15:4], rnd[7:4]}, "R8");
        end
        step(0, SYNC, 16'h0, 0, SYNC, 16'h0, "R6");
        step(0, SYNC, 16'h0, 0, SYNC, 16'h0, "R6");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule